// File: doc/BRIEF.md
# Sectioned Segment Descriptor Cache

This block holds recently used segment descriptors for an address translation unit. The cache is direct-mapped and split into four equal sections. The two most significant bits of a virtual address pick the section. A lookup port is purely combinational: it takes a virtual address and returns a hit flag, a two-word descriptor rebuilt from the stored entry, and the entry's modified flag. The table walker uses a fill port to install a descriptor after a miss. It uses a mark port to record that a page was modified or referenced.

Software manages the cache through a word-addressed register port. This port gives direct access to both words of every entry. It also holds one base and one length register per section, a small configuration register, and a virtual-address register. Some writes invalidate entries as a side effect. A base write clears a whole section. A virtual-address write clears the single entry that the written address indexes. A length write clears nothing. Walking the descriptor tables in memory happens outside this block.

Top module: `seg_desc_cache`

## Requirements
- R1: Address fields: va[31:30] is the section, va[29:17] is the segment select, the low log2(ENT_PER_SEC) bits of the segment select are the entry index, and the upper bits are the tag. The flat entry number is section*ENT_PER_SEC + index. Lookup results are combinational from the stored state.
- R2: A lookup hits only when bit 0 (good) of the entry's high word is 1 and the tag held in the top TAG_W bits of the low word equals the address tag. On a hit, word 0 is {TAG_W zeros, low[31-TAG_W:2], high[1], low[0]}, word 1 is the high word with bits 4:0 cleared, and the modified flag is high[1].
- R3: Writing a base register stores the data with bits 4:0 cleared, in the section given by offset bits 1:0 only, and clears the good bit of every entry in that section.
- R4: Writing a length register stores data bits 22:10, reads back in bits 22:10 with all other bits zero, and changes no cache entry.
- R5: Writing the virtual-address register stores the full word and clears the good bit of only the entry that the written address indexes, whatever its tag.
- R6: A mark with mark_mod=1 sets bit 1 of the indexed entry's high word. A mark with mark_mod=0 (referenced) changes nothing.
- R7: reg_addr[11:8] selects the group (0 low words, 1 high words, 2 bases, 3 lengths, 4 configuration, 5 virtual address), and reg_addr[6:2] is the word offset. Low and high words read and write directly. Other groups read as zero and ignore writes.
- R8: The configuration register keeps only data bits 2:0, and reads return zeros above bit 2.
- R9: After reset, every entry misses and all state reads as zero.
- R10: A fill stores low={tag, sd0[31-TAG_W:0]} and high={sd1[31:5], 000, sd0[1], 1}. A lookup in the same cycle as a fill to the same entry returns the old contents, and the new contents appear on the next cycle.
- R11: When several updates land in one cycle, they apply in order fill, then mark, then register write, so a register write (including its invalidation) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_sd0 | output | 32 | Rebuilt descriptor word 0 |
| lk_sd1 | output | 32 | Rebuilt descriptor word 1 |
| lk_mod | output | 1 | Cached modified flag |
| fill_en | input | 1 | Install a descriptor this cycle |
| fill_va | input | 32 | Address the descriptor belongs to |
| fill_sd0 | input | 32 | Descriptor word 0 |
| fill_sd1 | input | 32 | Descriptor word 1 |
| mark_en | input | 1 | Record a page access bit |
| mark_mod | input | 1 | 1 modified, 0 referenced |
| mark_va | input | 32 | Address whose entry is marked |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The hardest cases to reach are collisions inside a single cycle. These include a lookup racing a fill to the same entry, and a fill meeting an invalidating register write to the same index. The bench drives both strobes on the same falling edge. It samples the lookup before the next rising edge and again one cycle later, so it sees the old contents and then the resolved result. To confirm that section and single-entry invalidation are targeted, it first fills all entries with distinct tags. After each invalidating write it sweeps every entry, so any collateral loss shows up.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

    localparam int VA_W     = 32;
    localparam int SID_LSB  = 30;
    localparam int SSL_LSB  = 17;
    localparam int SSL_W    = 13;
    localparam int NUM_SEC  = 4;
    localparam int SEC_W    = 2;
    localparam int HI_GOOD  = 0;
    localparam int HI_MOD   = 1;
    localparam int ALIGN_W  = 5;
    localparam int LEN_LSB  = 10;
    localparam int LEN_W    = 13;
    localparam int CFG_W    = 3;
    localparam int OFF_W    = 5;

    typedef enum logic [3:0] {
        GRP_LO   = 4'h0,
        GRP_HI   = 4'h1,
        GRP_BASE = 4'h2,
        GRP_LEN  = 4'h3,
        GRP_CFG  = 4'h4,
        GRP_VAR  = 4'h5,
        GRP_NONE = 4'hF
    } reg_grp_e;

endpackage

// File: rtl/seg_desc_addr_split.sv
module seg_desc_addr_split
    import seg_desc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 10,
    parameter int TOT_W = 5
) (
    input  logic [VA_W-1:0]  va,
    output logic [TAG_W-1:0] tag,
    output logic [TOT_W-1:0] flat
);
    logic [SEC_W-1:0] sid;
    logic [IDX_W-1:0] idx;
    logic             unused_low;

    assign sid        = va[SID_LSB +: SEC_W];
    assign idx        = va[SSL_LSB +: IDX_W];
    assign tag        = va[SSL_LSB + IDX_W +: TAG_W];
    assign flat       = {sid, idx};
    assign unused_low = ^va[SSL_LSB-1:0];
endmodule

// File: rtl/seg_desc_reg_decode.sv
module seg_desc_reg_decode
    import seg_desc_pkg::*;
(
    input  logic [11:0]      addr,
    output reg_grp_e         grp,
    output logic [OFF_W-1:0] off,
    output logic [SEC_W-1:0] sec
);
    logic unused_bits;

    always_comb begin
        case (addr[11:8])
            4'h0:    grp = GRP_LO;
            4'h1:    grp = GRP_HI;
            4'h2:    grp = GRP_BASE;
            4'h3:    grp = GRP_LEN;
            4'h4:    grp = GRP_CFG;
            4'h5:    grp = GRP_VAR;
            default: grp = GRP_NONE;
        endcase
    end

    assign off         = addr[6:2];
    assign sec         = addr[2 +: SEC_W];
    assign unused_bits = ^{addr[7], addr[1:0]};
endmodule

// File: rtl/seg_desc_match.sv
module seg_desc_match
    import seg_desc_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic [31:0]      lo_word,
    input  logic [31:0]      hi_word,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [31:0]      sd0,
    output logic [31:0]      sd1,
    output logic             mod
);
    assign hit = hi_word[HI_GOOD] && (lo_word[31 -: TAG_W] == tag);
    assign sd0 = {{TAG_W{1'b0}}, lo_word[31-TAG_W:2], hi_word[HI_MOD], lo_word[0]};
    assign sd1 = {hi_word[31:ALIGN_W], {ALIGN_W{1'b0}}};
    assign mod = hi_word[HI_MOD];
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_desc_pkg::*;
#(
    parameter int ENT_PER_SEC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_sd0,
    output logic [31:0] lk_sd1,
    output logic        lk_mod,
    input  logic        fill_en,
    input  logic [31:0] fill_va,
    input  logic [31:0] fill_sd0,
    input  logic [31:0] fill_sd1,
    input  logic        mark_en,
    input  logic        mark_mod,
    input  logic [31:0] mark_va,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int IDX_W = (ENT_PER_SEC > 1) ? $clog2(ENT_PER_SEC) : 1;
    localparam int TAG_W = SSL_W - IDX_W;
    localparam int TOTAL = NUM_SEC * ENT_PER_SEC;
    localparam int TOT_W = SEC_W + IDX_W;

    typedef struct packed {
        logic [TOTAL-1:0][31:0]         lo;
        logic [TOTAL-1:0][31:0]         hi;
        logic [NUM_SEC-1:0][31:0]       base;
        logic [NUM_SEC-1:0][LEN_W-1:0]  len;
        logic [CFG_W-1:0]               cfg;
        logic [31:0]                    vaddr;
    } state_t;

    state_t state_q, state_d;

    logic [TAG_W-1:0] lk_tag, fl_tag, mk_tag, vw_tag;
    logic [TOT_W-1:0] lk_flat, fl_flat, mk_flat, vw_flat;
    reg_grp_e         grp;
    logic [OFF_W-1:0] off;
    logic [SEC_W-1:0] sec;
    logic [TOT_W-1:0] reg_flat;
    logic             unused_top;

    seg_desc_addr_split #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TOT_W(TOT_W)) u_split_lk (
        .va(lk_va), .tag(lk_tag), .flat(lk_flat));
    seg_desc_addr_split #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TOT_W(TOT_W)) u_split_fl (
        .va(fill_va), .tag(fl_tag), .flat(fl_flat));
    seg_desc_addr_split #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TOT_W(TOT_W)) u_split_mk (
        .va(mark_va), .tag(mk_tag), .flat(mk_flat));
    seg_desc_addr_split #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TOT_W(TOT_W)) u_split_vw (
        .va(reg_wdata), .tag(vw_tag), .flat(vw_flat));

    seg_desc_reg_decode u_dec (
        .addr(reg_addr), .grp(grp), .off(off), .sec(sec));

    assign reg_flat = off[TOT_W-1:0];

    seg_desc_match #(.TAG_W(TAG_W)) u_match (
        .lo_word (state_q.lo[lk_flat]),
        .hi_word (state_q.hi[lk_flat]),
        .tag     (lk_tag),
        .hit     (lk_hit),
        .sd0     (lk_sd0),
        .sd1     (lk_sd1),
        .mod     (lk_mod)
    );

    assign unused_top = ^{mk_tag, vw_tag, fill_sd0[31 -: TAG_W],
                          fill_sd1[ALIGN_W-1:0], off};

    // Next-state: fill, then mark, then register write (later wins).
    always_comb begin
        state_d = state_q;

        if (fill_en) begin
            state_d.lo[fl_flat] = {fl_tag, fill_sd0[31-TAG_W:0]};
            state_d.hi[fl_flat] = {fill_sd1[31:ALIGN_W], 3'b000,
                                   fill_sd0[HI_MOD], 1'b1};
        end

        if (mark_en && mark_mod) begin
            state_d.hi[mk_flat][HI_MOD] = 1'b1;
        end

        if (reg_wr) begin
            case (grp)
                GRP_LO:  state_d.lo[reg_flat] = reg_wdata;
                GRP_HI:  state_d.hi[reg_flat] = reg_wdata;
                GRP_BASE: begin
                    state_d.base[sec] = {reg_wdata[31:ALIGN_W], {ALIGN_W{1'b0}}};
                    for (int e = 0; e < ENT_PER_SEC; e++) begin
                        state_d.hi[{sec, IDX_W'(e)}][HI_GOOD] = 1'b0;
                    end
                end
                GRP_LEN: state_d.len[sec] = reg_wdata[LEN_LSB +: LEN_W];
                GRP_CFG: state_d.cfg = reg_wdata[CFG_W-1:0];
                GRP_VAR: begin
                    state_d.vaddr = reg_wdata;
                    state_d.hi[vw_flat][HI_GOOD] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (grp)
            GRP_LO:   reg_rdata = state_q.lo[reg_flat];
            GRP_HI:   reg_rdata = state_q.hi[reg_flat];
            GRP_BASE: reg_rdata = state_q.base[sec];
            GRP_LEN:  reg_rdata = {{(32-LEN_LSB-LEN_W){1'b0}}, state_q.len[sec],
                                   {LEN_LSB{1'b0}}};
            GRP_CFG:  reg_rdata = {{(32-CFG_W){1'b0}}, state_q.cfg};
            GRP_VAR:  reg_rdata = state_q.vaddr;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/seg_desc_cache_chk.sv
module seg_desc_cache_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] lk_va,
    input logic        lk_hit,
    input logic [31:0] lk_sd1,
    input logic        lk_mod,
    input logic        fill_en,
    input logic [31:0] fill_va,
    input logic [31:0] fill_sd1,
    input logic        mark_en,
    input logic        mark_mod,
    input logic [31:0] mark_va,
    input logic        reg_wr,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    // R9: first cycle out of reset sees an empty cache
    a_r9_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R10 / R2: a fill is visible on the following cycle
    a_r10_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !reg_wr) |=>
            (lk_va != $past(fill_va)) ||
            (lk_hit && lk_sd1 == {$past(fill_sd1[31:5]), 5'b0}));

    // R3: base write empties the addressed section
    a_r3_base_clears_section: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[11:8] == 4'h2) |=>
            (lk_va[31:30] != $past(reg_addr[3:2])) || !lk_hit);

    // R4: length write leaves lookups unchanged
    a_r4_len_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[11:8] == 4'h3 && !fill_en && !mark_en) |=>
            (lk_va != $past(lk_va)) || (lk_hit == $past(lk_hit)));

    // R5: address write empties the entry it indexes
    a_r5_var_clears_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[11:8] == 4'h5) |=>
            (lk_va != $past(reg_wdata)) || !lk_hit);

    // R6: modified mark shows up on a hit
    a_r6_mod_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && mark_mod && !reg_wr && !fill_en) |=>
            (lk_va != $past(mark_va)) || !lk_hit || lk_mod);

    // R8: configuration reads only three bits
    a_r8_cfg_width: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[11:8] == 4'h4) |-> (reg_rdata[31:3] == 29'd0));
endmodule

bind seg_desc_cache seg_desc_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_sd1(lk_sd1), .lk_mod(lk_mod), .fill_en(fill_en), .fill_va(fill_va),
    .fill_sd1(fill_sd1), .mark_en(mark_en), .mark_mod(mark_mod),
    .mark_va(mark_va), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/seg_desc_cache_bench.sv
module seg_desc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_sd0, lk_sd1;
    logic        lk_mod;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0, fill_sd0 = '0, fill_sd1 = '0;
    logic        mark_en = 1'b0, mark_mod = 1'b0;
    logic [31:0] mark_va = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];

    always #2 clk = ~clk;

    seg_desc_cache u_seg_desc_cache (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
        .lk_sd0(lk_sd0), .lk_sd1(lk_sd1), .lk_mod(lk_mod),
        .fill_en(fill_en), .fill_va(fill_va), .fill_sd0(fill_sd0),
        .fill_sd1(fill_sd1), .mark_en(mark_en), .mark_mod(mark_mod),
        .mark_va(mark_va), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(input int flat, input logic [9:0] tag);
        return {2'(flat >> 3), tag, 3'(flat), 17'h0ACE};
    endfunction

    function automatic logic [31:0] pat0(input int i);
        return 32'h5A3C_96E1 ^ (32'(i) * 32'h0104_2083);
    endfunction

    function automatic logic [31:0] pat1(input int i);
        return 32'hC0DE_0000 + (32'(i) * 32'h0001_1357);
    endfunction

    // Expected lookup from the model, per R2
    task automatic check_entry(input string req, input int flat, input logic [9:0] tag);
        logic exp_hit;
        lk_va = mkva(flat, tag);
        #1;
        exp_hit = m_hi[flat][0] && (m_lo[flat][31:22] == tag);
        chk(req, {31'd0, lk_hit}, {31'd0, exp_hit});
        if (exp_hit) begin
            chk(req, lk_sd0, {10'd0, m_lo[flat][21:2], m_hi[flat][1], m_lo[flat][0]});
            chk(req, lk_sd1, m_hi[flat] & 32'hFFFF_FFE0);
            chk(req, {31'd0, lk_mod}, {31'd0, m_hi[flat][1]});
        end
    endtask

    task automatic model_fill(input int flat, input logic [9:0] tag,
                              input logic [31:0] s0, input logic [31:0] s1);
        m_lo[flat] = {tag, s0[21:0]};
        m_hi[flat] = {s1[31:5], 3'b000, s0[1], 1'b1};
    endtask

    task automatic do_fill(input int flat, input logic [9:0] tag,
                           input logic [31:0] s0, input logic [31:0] s1);
        @(negedge clk);
        fill_en = 1; fill_va = mkva(flat, tag); fill_sd0 = s0; fill_sd1 = s1;
        @(negedge clk);
        fill_en = 0;
        model_fill(flat, tag, s0, s1);
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [11:0] ra(input logic [3:0] grp, input int offs);
        return {grp, 1'b0, 5'(offs), 2'b00};
    endfunction

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: everything empty after reset
        for (int i = 0; i < 32; i++) begin
            check_entry("R9 miss after reset", i, 10'(i * 7));
            reg_read(ra(4'h1, i), rd);
            chk("R9 high word zero", rd, 32'd0);
        end

        // R1/R2/R10: fill all entries with distinct tags
        for (int i = 0; i < 32; i++) do_fill(i, 10'(i * 37 + 5), pat0(i), pat1(i));
        for (int i = 0; i < 32; i++) begin
            check_entry("R1 R2 hit after fill", i, 10'(i * 37 + 5));
            check_entry("R2 miss on other tag", i, 10'(i * 37 + 6));
        end

        // R7 / R10: raw word readback of fill layout
        for (int i = 0; i < 32; i += 5) begin
            reg_read(ra(4'h0, i), rd);
            chk("R7 R10 low word", rd, m_lo[i]);
            reg_read(ra(4'h1, i), rd);
            chk("R7 R10 high word", rd, m_hi[i]);
        end
        reg_read(ra(4'h7, 3), rd);
        chk("R7 unused group reads zero", rd, 32'd0);

        // R10: same-cycle lookup and fill
        @(negedge clk);
        fill_en = 1; fill_va = mkva(5, 10'h2AA); fill_sd0 = 32'h0012_3457; fill_sd1 = 32'h8765_4321;
        lk_va = mkva(5, 10'(5 * 37 + 5));
        #1;
        chk("R10 old contents same cycle", {31'd0, lk_hit}, 32'd1);
        chk("R10 old sd1 same cycle", lk_sd1, m_hi[5] & 32'hFFFF_FFE0);
        @(negedge clk);
        fill_en = 0;
        model_fill(5, 10'h2AA, 32'h0012_3457, 32'h8765_4321);
        check_entry("R10 new contents next cycle", 5, 10'h2AA);
        check_entry("R10 old tag gone", 5, 10'(5 * 37 + 5));

        // R6: referenced mark no effect, modified mark sets bit 1
        do_fill(12, 10'h155, 32'h0000_0F00, 32'h4000_0040);
        @(negedge clk);
        mark_en = 1; mark_mod = 0; mark_va = mkva(12, 10'h155);
        @(negedge clk);
        mark_en = 0;
        reg_read(ra(4'h1, 12), rd);
        chk("R6 referenced mark ignored", rd, m_hi[12]);
        check_entry("R6 mod clear before", 12, 10'h155);
        @(negedge clk);
        mark_en = 1; mark_mod = 1;
        @(negedge clk);
        mark_en = 0;
        m_hi[12][1] = 1'b1;
        check_entry("R6 modified mark sets flag", 12, 10'h155);
        reg_read(ra(4'h1, 12), rd);
        chk("R6 high word bit 1", rd, m_hi[12]);

        // R4: length write keeps entries
        reg_write(ra(4'h3, 1), 32'hFFFF_FFFF);
        reg_read(ra(4'h3, 1), rd);
        chk("R4 length readback", rd, 32'h007F_FC00);
        for (int i = 0; i < 32; i++) check_entry("R4 no invalidation", i, m_lo[i][31:22]);

        // R3: base write via offset 6 selects section 2
        reg_write(ra(4'h2, 6), 32'h1234_567F);
        reg_read(ra(4'h2, 2), rd);
        chk("R3 base aligned", rd, 32'h1234_5660);
        reg_read(ra(4'h2, 0), rd);
        chk("R3 other base untouched", rd, 32'd0);
        for (int i = 16; i < 24; i++) m_hi[i][0] = 1'b0;
        for (int i = 0; i < 32; i++) check_entry("R3 section sweep", i, m_lo[i][31:22]);

        // R5: address write clears one entry regardless of tag
        reg_write(ra(4'h5, 0), mkva(3, 10'h3FF));
        reg_read(ra(4'h5, 0), rd);
        chk("R5 address readback", rd, mkva(3, 10'h3FF));
        m_hi[3][0] = 1'b0;
        for (int i = 0; i < 32; i++) check_entry("R5 single entry sweep", i, m_lo[i][31:22]);

        // R8: configuration width
        reg_write(ra(4'h4, 0), 32'hFFFF_FFFF);
        reg_read(ra(4'h4, 0), rd);
        chk("R8 config three bits", rd, 32'h0000_0007);
        reg_write(ra(4'h4, 0), 32'hFFFF_FFFA);
        reg_read(ra(4'h4, 0), rd);
        chk("R8 config value", rd, 32'h0000_0002);

        // R7: direct word writes build a valid entry
        reg_write(ra(4'h0, 17), {10'h0C3, 22'h0ABCD1});
        reg_write(ra(4'h1, 17), 32'h7777_7003);
        m_lo[17] = {10'h0C3, 22'h0ABCD1};
        m_hi[17] = 32'h7777_7003;
        check_entry("R7 direct write hit", 17, 10'h0C3);

        // R11: fill and invalidating address write in one cycle
        @(negedge clk);
        fill_en = 1; fill_va = mkva(9, 10'h011); fill_sd0 = 32'h0000_0002; fill_sd1 = 32'h0000_1000;
        reg_wr = 1; reg_addr = ra(4'h5, 0); reg_wdata = mkva(9, 10'h222);
        @(negedge clk);
        fill_en = 0; reg_wr = 0;
        model_fill(9, 10'h011, 32'h0000_0002, 32'h0000_1000);
        m_hi[9][0] = 1'b0;
        check_entry("R11 register write wins", 9, 10'h011);
        reg_read(ra(4'h0, 9), rd);
        chk("R11 fill low word kept", rd, m_lo[9]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule